// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit microcontroller core. The core hands it two operands and a five-bit operation code. It returns a result at once. One clock edge later it writes the new condition flags into its own status register. The supported operations are:

- addition, with and without carry-in
- subtraction and compare, with and without borrow-in
- AND, OR, XOR and one's complement
- two's-complement negate
- increment and decrement
- nibble swap
- three right shifts: arithmetic, logical and rotate through carry

The status byte holds eight bits, from bit 0 upward: C (carry), Z (zero), N (negative), V (overflow), S (sign), H (half carry), T (bit store) and I (interrupt enable). The block computes the six arithmetic flags. The T and I bits are only carried along. The core can overwrite the whole status byte through a load port. Compare operations raise a no-writeback indication so that the core leaves the destination register untouched.

Top module: `alu8_flagged`

## Requirements
- R1: While `rst_n` is low, and after its release until the first update, `status` reads 0x00.
- R2: ADD (op 0) returns a+b and ADC (op 1) returns a+b+C. H is the carry out of bit 3 and C the carry out of bit 7. V flags signed overflow, N is result bit 7, S = N xor V, and Z is set for a zero result.
- R3: SUB (op 2) returns a-b. H is the borrow out of bit 3 and C the borrow out of bit 7. V flags signed overflow, N is result bit 7, S = N xor V, and Z is set for a zero result.
- R4: SBC (op 3) returns a-b-C and sets H, C, V, N and S as in R3. Z becomes 1 only when the result is zero and Z was already 1.
- R5: CP (op 4) flags like SUB and CPC (op 5) flags like SBC. For these two codes `no_wb` is 1. For every other code from 0 to 16, `no_wb` is 0.
- R6: AND (6), OR (7), XOR (8) and COM (9, result ~a) do the following:
  - clear V
  - set N from result bit 7, with S = N
  - set Z on a zero result
  - keep H

  AND, OR and XOR keep C. COM sets C to 1.
- R7: NEG (op 10) returns 0-a. C = (a != 0) and Z = (result == 0). V is 1 only for a result of 0x80. N is result bit 7 and S = N xor V. H is bit 3 of (result | a).
- R8: INC (op 11) and DEC (op 12) return a+1 and a-1 and keep C and H. V is 1 only when INC yields 0x80 or DEC yields 0x7F. N is result bit 7, S = N xor V, and Z is set on a zero result.
- R9: ASR (op 14) keeps bit 7, LSR (op 15) shifts a 0 into bit 7, and ROR (op 16) shifts the old C into bit 7. All three put a[0] into C, set N from result bit 7, V = N xor C and S = N xor V, and set Z on a zero result. H is kept.
- R10: SWAP (op 13) exchanges the high and low nibbles of a and leaves all eight status bits unchanged.
- R11: Status bits 7 (I) and 6 (T) keep their value through every operation.
- R12: With `st_load` high, `status` takes `st_wdata` at the next edge, even if `op_valid` is also high. With both low, `status` holds.
- R13: Codes 17 to 31 are undefined. They return a unchanged, drive `no_wb` to 1 and leave `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Commit this cycle's flags into the status register |
| op_sel | input | 5 | Operation code (see requirements) |
| opa | input | 8 | First operand; the sole operand of unary operations |
| opb | input | 8 | Second operand |
| st_load | input | 1 | Overwrite the status register |
| st_wdata | input | 8 | Value for a status overwrite |
| result | output | 8 | Combinational result |
| no_wb | output | 1 | Destination must not be written |
| status | output | 8 | Registered status byte |

## Verification
`result` and `no_wb` are combinational and are due in the same cycle as the operands. The flags land in `status` at the first rising edge on which `op_valid` or `st_load` is high. The bench changes inputs on the falling edge. It compares `result` and `no_wb` one time unit later against a behavioural model that derives carries, borrows and overflow from integer arithmetic. It then compares `status` one time unit after the following rising edge, which is the edge the model itself advances on.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   // status bit positions
   localparam int FC = 0;
   localparam int FZ = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FS = 4;
   localparam int FH = 5;
   localparam int FT = 6;
   localparam int FI = 7;

   localparam int OPW = 5;
   localparam int STW = 8;

   typedef enum logic [OPW-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CP   = 5'd4,
      OP_CPC  = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_COM  = 5'd9,
      OP_NEG  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_SWAP = 5'd13,
      OP_ASR  = 5'd14,
      OP_LSR  = 5'd15,
      OP_ROR  = 5'd16
   } alu_op_e;

   // selects for the logic and shift units
   localparam logic [1:0] LG_AND = 2'd0;
   localparam logic [1:0] LG_OR  = 2'd1;
   localparam logic [1:0] LG_XOR = 2'd2;
   localparam logic [1:0] LG_COM = 2'd3;

   localparam logic [1:0] SH_ASR  = 2'd0;
   localparam logic [1:0] SH_LSR  = 2'd1;
   localparam logic [1:0] SH_ROR  = 2'd2;
   localparam logic [1:0] SH_SWAP = 2'd3;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic [W-1:0] cvec,
   output logic         ovf
);
   localparam int MSB = W - 1;

   logic [W-1:0] ovec;

   always_comb begin
      if (sub) begin
         sum  = x - y - {{(W-1){1'b0}}, cin};
         cvec = (~x & y) | (y & sum) | (sum & ~x);
         ovec = (x & ~y & ~sum) | (~x & y & sum);
      end else begin
         sum  = x + y + {{(W-1){1'b0}}, cin};
         cvec = (x & y) | (x & ~sum) | (y & ~sum);
         ovec = (x & y & ~sum) | (~x & ~y & sum);
      end
      ovf = ovec[MSB];
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [1:0]   sel,
   output logic [W-1:0] r
);
   import alu8_pkg::*;

   always_comb begin
      unique case (sel)
         LG_AND:  r = x & y;
         LG_OR:   r = x | y;
         LG_XOR:  r = x ^ y;
         default: r = ~x;
      endcase
   end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic         cin,
   input  logic [1:0]   mode,
   output logic [W-1:0] r
);
   import alu8_pkg::*;

   localparam int MSB  = W - 1;
   localparam int HALF = W / 2;

   logic [W-1:0] swp;
   logic         top_in;

   for (genvar i = 0; i < HALF; i++) begin : g_swap
      assign swp[i]        = x[i+HALF];
      assign swp[i+HALF]   = x[i];
   end

   always_comb begin
      unique case (mode)
         SH_ASR:  top_in = x[MSB];
         SH_LSR:  top_in = 1'b0;
         default: top_in = cin;
      endcase
      r = (mode == SH_SWAP) ? swp : {top_in, x[MSB:1]};
   end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged #(
   parameter int         W          = 8,
   parameter logic [7:0] RST_STATUS = 8'h00
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [4:0]   op_sel,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         st_load,
   input  logic [7:0]   st_wdata,
   output logic [W-1:0] result,
   output logic         no_wb,
   output logic [7:0]   status
);
   import alu8_pkg::*;

   localparam int MSB = W - 1;
   localparam int HB  = W / 2 - 1;

   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("alu8_flagged: W must be even and at least 4");
   end

   logic [STW-1:0] st_q;
   logic [STW-1:0] st_nx;
   logic [W-1:0]   ax, bx, ar, cv, lr, sr, res;
   logic           ci, sb, ov, nwb;
   logic [1:0]     lsel, smode;

   // operand steering for the shared adder
   always_comb begin
      ax = opa;
      bx = opb;
      ci = 1'b0;
      sb = 1'b0;
      case (op_sel)
         OP_ADC:          ci = st_q[FC];
         OP_SUB, OP_CP:   sb = 1'b1;
         OP_SBC, OP_CPC: begin
            sb = 1'b1;
            ci = st_q[FC];
         end
         OP_NEG: begin
            ax = '0;
            bx = opa;
            sb = 1'b1;
         end
         OP_INC:          bx = W'(1);
         OP_DEC: begin
            bx = W'(1);
            sb = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      case (op_sel)
         OP_OR:   lsel = LG_OR;
         OP_XOR:  lsel = LG_XOR;
         OP_COM:  lsel = LG_COM;
         default: lsel = LG_AND;
      endcase
      case (op_sel)
         OP_LSR:  smode = SH_LSR;
         OP_ROR:  smode = SH_ROR;
         OP_SWAP: smode = SH_SWAP;
         default: smode = SH_ASR;
      endcase
   end

   alu8_addsub #(.W(W)) u_addsub (
      .x    (ax),
      .y    (bx),
      .cin  (ci),
      .sub  (sb),
      .sum  (ar),
      .cvec (cv),
      .ovf  (ov)
   );

   alu8_logic #(.W(W)) u_logic (
      .x   (opa),
      .y   (opb),
      .sel (lsel),
      .r   (lr)
   );

   alu8_shift #(.W(W)) u_shift (
      .x    (opa),
      .cin  (st_q[FC]),
      .mode (smode),
      .r    (sr)
   );

   // result select and flag composition
   always_comb begin
      st_nx = st_q;
      res   = opa;
      nwb   = 1'b0;
      case (op_sel)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
            res       = ar;
            st_nx[FH] = cv[HB];
            st_nx[FC] = cv[MSB];
            st_nx[FV] = ov;
            st_nx[FN] = ar[MSB];
            st_nx[FS] = ar[MSB] ^ ov;
            if (op_sel == OP_SBC || op_sel == OP_CPC)
               st_nx[FZ] = (ar == '0) & st_q[FZ];
            else
               st_nx[FZ] = (ar == '0);
            nwb = (op_sel == OP_CP) || (op_sel == OP_CPC);
         end
         OP_INC, OP_DEC: begin
            res       = ar;
            st_nx[FV] = ov;
            st_nx[FN] = ar[MSB];
            st_nx[FS] = ar[MSB] ^ ov;
            st_nx[FZ] = (ar == '0);
         end
         OP_AND, OP_OR, OP_XOR, OP_COM: begin
            res       = lr;
            st_nx[FV] = 1'b0;
            st_nx[FN] = lr[MSB];
            st_nx[FS] = lr[MSB];
            st_nx[FZ] = (lr == '0);
            if (op_sel == OP_COM)
               st_nx[FC] = 1'b1;
         end
         OP_ASR, OP_LSR, OP_ROR: begin
            res       = sr;
            st_nx[FC] = opa[0];
            st_nx[FN] = sr[MSB];
            st_nx[FV] = sr[MSB] ^ opa[0];
            st_nx[FS] = opa[0];
            st_nx[FZ] = (sr == '0);
         end
         OP_SWAP: res = sr;
         default: nwb = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= RST_STATUS;
      else if (st_load)
         st_q <= st_wdata;
      else if (op_valid)
         st_q <= st_nx;
   end

   assign result = res;
   assign no_wb  = nwb;
   assign status = st_q;
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [4:0]   op_sel,
   input logic [W-1:0] opa,
   input logic         st_load,
   input logic [7:0]   st_wdata,
   input logic         no_wb,
   input logic [7:0]   status
);
   import alu8_pkg::*;

   logic upd, is_cmp, is_logic, is_shift;
   assign upd      = op_valid && !st_load;
   assign is_cmp   = (op_sel == OP_CP) || (op_sel == OP_CPC);
   assign is_logic = (op_sel == OP_AND) || (op_sel == OP_OR) ||
                     (op_sel == OP_XOR) || (op_sel == OP_COM);
   assign is_shift = (op_sel == OP_ASR) || (op_sel == OP_LSR) || (op_sel == OP_ROR);

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      st_load |=> status == $past(st_wdata)); // R12
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !st_load) |=> $stable(status)); // R12
   AST_IT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> status[FI:FT] == $past(status[FI:FT])); // R11
   AST_SWAP_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && op_sel == OP_SWAP) |=> $stable(status)); // R10
   AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && op_sel > OP_ROR) |=> $stable(status)); // R13
   AST_CMP_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmp |-> no_wb); // R5
   AST_OTHER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel <= OP_ROR && !is_cmp) |-> !no_wb); // R5
   AST_LOGIC_VCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && is_logic) |=> !status[FV] && (status[FS] == status[FN])); // R6
   AST_COM_CSET: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && op_sel == OP_COM) |=> status[FC]); // R6
   AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && is_shift) |=> status[FC] == $past(opa[0])); // R9
endmodule

bind alu8_flagged alu8_flagged_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_sel   (op_sel),
   .opa      (opa),
   .st_load  (st_load),
   .st_wdata (st_wdata),
   .no_wb    (no_wb),
   .status   (status)
);

// File: tb/alu8_flagged_tb.sv
module alu8_flagged_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_sel = '0;
   logic [7:0] opa = '0;
   logic [7:0] opb = '0;
   logic       st_load = 1'b0;
   logic [7:0] st_wdata = '0;
   logic [7:0] result;
   logic       no_wb;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   int exp_st = 0;

   alu8_flagged u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opa(opa), .opb(opb), .st_load(st_load), .st_wdata(st_wdata),
      .result(result), .no_wb(no_wb), .status(status)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int s8(int v);
      return (v & 128) ? v - 256 : v;
   endfunction

   function automatic string tag_of(int op);
      case (op)
         0, 1:           return "R2";
         2:              return "R3";
         3:              return "R4";
         4, 5:           return "R5";
         6, 7, 8, 9:     return "R6";
         10:             return "R7";
         11, 12:         return "R8";
         13:             return "R10";
         14, 15, 16:     return "R9";
         default:        return "R13";
      endcase
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: integer arithmetic, flags from ranges
   task automatic model(input int op, input int a, input int b, input int st,
                        output int r, output int nw, output int ns);
      int c, z, n, v, s, h, ci, t;
      c = st & 1; z = (st >> 1) & 1; n = (st >> 2) & 1;
      v = (st >> 3) & 1; s = (st >> 4) & 1; h = (st >> 5) & 1;
      r = a; nw = 0; ns = st;
      case (op)
         0, 1: begin
            ci = (op == 1) ? c : 0;
            t  = a + b + ci;
            r  = t & 255;
            c  = (t > 255);
            h  = ((a & 15) + (b & 15) + ci) > 15;
            t  = s8(a) + s8(b) + ci;
            v  = (t > 127 || t < -128);
            n  = r >> 7; s = n ^ v; z = (r == 0);
         end
         2, 3, 4, 5, 10: begin
            int x, y;
            x  = (op == 10) ? 0 : a;
            y  = (op == 10) ? a : b;
            ci = (op == 3 || op == 5) ? c : 0;
            t  = x - y - ci;
            r  = t & 255;
            c  = (t < 0);
            h  = ((x & 15) - (y & 15) - ci) < 0;
            t  = s8(x) - s8(y) - ci;
            v  = (t > 127 || t < -128);
            n  = r >> 7; s = n ^ v;
            z  = (op == 3 || op == 5) ? ((r == 0) && z) : (r == 0);
            nw = (op == 4 || op == 5);
         end
         11, 12: begin
            r = (op == 11) ? ((a + 1) & 255) : ((a + 255) & 255);
            v = (op == 11) ? (a == 127) : (a == 128);
            n = r >> 7; s = n ^ v; z = (r == 0);
         end
         6, 7, 8, 9: begin
            if (op == 6) r = a & b;
            else if (op == 7) r = a | b;
            else if (op == 8) r = a ^ b;
            else begin r = (~a) & 255; c = 1; end
            v = 0; n = r >> 7; s = n; z = (r == 0);
         end
         14, 15, 16: begin
            if (op == 14) r = (a >> 1) | (a & 128);
            else if (op == 15) r = a >> 1;
            else r = (a >> 1) | (c << 7);
            c = a & 1; n = r >> 7; v = n ^ c; s = n ^ v; z = (r == 0);
         end
         13: r = ((a & 15) << 4) | (a >> 4);
         default: nw = 1;
      endcase
      if (op <= 16 && op != 13)
         ns = (st & 8'hC0) | (h << 5) | (s << 4) | (v << 3) | (n << 2) | (z << 1) | c;
   endtask

   task automatic step(int op, int a, int b, bit valid, bit ld, int wd);
      int r, nw, ns;
      string t;
      @(negedge clk);
      op_sel = op[4:0]; opa = a[7:0]; opb = b[7:0];
      op_valid = valid; st_load = ld; st_wdata = wd[7:0];
      #1;
      model(op, a, b, exp_st, r, nw, ns);
      chk(tag_of(op), "result", int'(result), r);
      chk((op == 4 || op == 5 || op > 16) ? tag_of(op) : "R5", "no_wb", int'(no_wb), nw);
      @(posedge clk);
      if (ld) begin exp_st = wd & 255; t = "R12"; end
      else if (valid) begin exp_st = ns; t = tag_of(op); end
      else t = "R12";
      #1;
      chk(t, "status", int'(status), exp_st);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      #(CLK_PERIOD * 2 + 3);
      chk("R1", "status in reset", int'(status), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "status after reset", int'(status), 0);

      // R2 add
      step(0, 8'h0F, 8'h01, 1, 0, 0);
      step(0, 8'h80, 8'h80, 1, 0, 0);
      step(0, 8'h7F, 8'h01, 1, 0, 0);
      step(1, 8'hFF, 8'h00, 1, 1, 8'h01);
      step(1, 8'hFF, 8'h00, 1, 0, 0);
      // R3 subtract
      step(2, 8'h00, 8'h01, 1, 0, 0);
      step(2, 8'h80, 8'h01, 1, 0, 0);
      step(2, 8'h44, 8'h44, 1, 0, 0);
      // R4 zero chaining
      step(0, 0, 0, 0, 1, 8'h02);
      step(3, 8'h05, 8'h05, 1, 0, 0);
      step(0, 0, 0, 0, 1, 8'h00);
      step(3, 8'h05, 8'h05, 1, 0, 0);
      step(0, 0, 0, 0, 1, 8'h03);
      step(3, 8'h06, 8'h05, 1, 0, 0);
      // R5 compares
      step(4, 8'h10, 8'h10, 1, 0, 0);
      step(0, 0, 0, 0, 1, 8'h02);
      step(5, 8'h20, 8'h20, 1, 0, 0);
      step(5, 8'h10, 8'h20, 1, 0, 0);
      // R6 logic
      step(0, 0, 0, 0, 1, 8'h21);
      step(6, 8'hF0, 8'h0F, 1, 0, 0);
      step(7, 8'h80, 8'h01, 1, 0, 0);
      step(8, 8'hAA, 8'hAA, 1, 0, 0);
      step(0, 0, 0, 0, 1, 8'h00);
      step(9, 8'hFF, 0, 1, 0, 0);
      // R7 negate
      step(10, 8'h80, 0, 1, 0, 0);
      step(10, 8'h00, 0, 1, 0, 0);
      step(10, 8'h01, 0, 1, 0, 0);
      step(10, 8'h10, 0, 1, 0, 0);
      // R8 inc/dec
      step(0, 0, 0, 0, 1, 8'h21);
      step(11, 8'h7F, 0, 1, 0, 0);
      step(11, 8'hFF, 0, 1, 0, 0);
      step(12, 8'h80, 0, 1, 0, 0);
      step(12, 8'h01, 0, 1, 0, 0);
      // R9 shifts
      step(14, 8'h81, 0, 1, 0, 0);
      step(15, 8'h01, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1, 8'h01);
      step(16, 8'h02, 0, 1, 0, 0);
      step(16, 8'h01, 0, 1, 0, 0);
      // R10 swap
      step(0, 0, 0, 0, 1, 8'h3F);
      step(13, 8'hA5, 0, 1, 0, 0);
      // R13 undefined codes
      step(17, 8'h5A, 8'h11, 1, 0, 0);
      step(31, 8'h00, 8'hFF, 1, 0, 0);
      // R12 priority and hold
      step(0, 8'hFF, 8'h01, 1, 1, 8'h55);
      step(0, 8'hFF, 8'h01, 0, 0, 0);
      // R11 I and T survive a run of operations
      step(0, 0, 0, 0, 1, 8'hC0);
      for (int op = 0; op <= 16; op++)
         step(op, 8'h93, 8'h6D, 1, 0, 0);
      chk("R11", "I/T bits", int'(status[7:6]), 3);

      for (int i = 0; i < 3000; i++) begin
         int op, a, b, ld, vl, wd;
         op = $urandom_range(0, 31);
         a  = $urandom_range(0, 255);
         b  = $urandom_range(0, 255);
         ld = ($urandom_range(0, 9) == 0);
         vl = ($urandom_range(0, 7) != 0);
         wd = $urandom_range(0, 255);
         step(op, a, b, vl[0], ld[0], wd);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule